// File: doc/BRIEF.md
# Guarded Clock Source Select Register

This block is an 8-bit control register. Its top bit chooses where the system clocks come from: the oscillator clock or a PLL clock. The other seven bits set how the clocks behave in wait mode and stop mode. Software reads and writes the register over a simple register port.

Three status inputs report whether the PLL is usable: lock, track and auto. A write that asks for the PLL clock is refused while the PLL is not stable. The block also clears the PLL-select bit by itself when the device enters stop mode or self-clock mode. It clears the bit on entry to wait mode too, but only when the PLL is set to power down in wait.

Level inputs tell the block when the device is in wait or stop mode. From those levels and the register bits it drives the low-power control outputs: PLL power-down, system-clock gating, oscillator enable and amplitude, and wait-mode stop requests for the CPU, the periodic tick and the watchdog.

Top module: `clk_src_sel_reg`

## Requirements
- R1: After reset, all eight register bits read 0 and pll_sel is 0. In this state osc_en is 1 and every mode output is 0 while neither mode level is active.
- R2: pll_sel (register bit 7) selects the source: 0 means the oscillator and 1 means the PLL. A write with bit 7 = 1 while the PLL is stable sets pll_sel at the next clock edge. A write with bit 7 = 0 clears it. pll_sel changes only on a clock edge.
- R3: A write with bit 7 = 1 leaves bit 7 unchanged when the PLL is unstable. This covers effective auto = 1 with lock = 0, and effective auto = 0 with track = 0. A bit 7 that is already 1 stays 1.
- R4: Effective auto is auto_in OR register bit 3, and it is driven on auto_eff. The PLL counts as stable when (auto_eff AND lock) OR (NOT auto_eff AND track).
- R5: A stop_enter or selfclk_enter pulse clears bit 7 at the next edge. Bits 6:0 keep their values.
- R6: A wait_enter pulse clears bit 7 when bit 3 is 1, and leaves it alone when bit 3 is 0. After wait mode ends, bit 7 stays 0 until software writes it again.
- R7: An automatic clear in the same cycle as a write that sets bit 7 wins: bit 7 ends at 0. Bits 6:0 still take the write data.
- R8: Bits 6:0 take the write data on any write and read back at the same positions. Bit 6 is keep-oscillator-in-stop, bit 5 is gate-system-clock-in-wait, bit 4 is low-amplitude-in-wait, and bit 3 is PLL-off-in-wait. Bits 2, 1 and 0 are the CPU, tick and watchdog wait stops. Without a write or a clear the register holds its value.
- R9: pll_pwrdn is in_wait AND bit 3. sys_clk_off is in_wait AND bit 5.
- R10: osc_en is NOT in_stop OR bit 6. osc_low_amp is (in_wait AND bit 4) OR (in_stop AND bit 6).
- R11: cpu_stop, tick_stop and dog_stop are in_wait ANDed with bits 2, 1 and 0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| lock_in | input | 1 | PLL lock status |
| track_in | input | 1 | PLL track status |
| auto_in | input | 1 | Automatic bandwidth control from the PLL control |
| wait_enter | input | 1 | One-cycle pulse on entry to wait mode |
| stop_enter | input | 1 | One-cycle pulse on entry to stop mode |
| selfclk_enter | input | 1 | One-cycle pulse on entry to self-clock mode |
| in_wait | input | 1 | High while in wait mode |
| in_stop | input | 1 | High while in stop mode |
| pll_sel | output | 1 | Source select for the clock multiplexer |
| auto_eff | output | 1 | Effective auto control after forcing by bit 3 |
| pll_pwrdn | output | 1 | PLL power-down request |
| sys_clk_off | output | 1 | System clock gate request |
| osc_en | output | 1 | Oscillator enable |
| osc_low_amp | output | 1 | Reduced oscillator amplitude request |
| cpu_stop | output | 1 | CPU clock stop in wait |
| tick_stop | output | 1 | Periodic tick stop in wait |
| dog_stop | output | 1 | Watchdog stop in wait |

## Verification
The assertions check on every cycle the rules that can be seen in a single step. A refused write never raises pll_sel, and pll_sel rises only after a write with bit 7 set. Each entry pulse that clears the bit leaves it at 0 on the next cycle. Bit 3 forces auto_eff high, and bits 6:0 hold still without a write. Some behaviour shows only in the bench's scenarios: bit 7 staying clear across a whole stay in wait mode, the result of a clear and a write in the same cycle, and the mode outputs under the different bit patterns.

// File: rtl/clk_src_sel_reg.sv
module clk_src_sel_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         lock_in,
  input  logic         track_in,
  input  logic         auto_in,
  input  logic         wait_enter,
  input  logic         stop_enter,
  input  logic         selfclk_enter,
  input  logic         in_wait,
  input  logic         in_stop,
  output logic         pll_sel,
  output logic         auto_eff,
  output logic         pll_pwrdn,
  output logic         sys_clk_off,
  output logic         osc_en,
  output logic         osc_low_amp,
  output logic         cpu_stop,
  output logic         tick_stop,
  output logic         dog_stop
);
  localparam int SEL  = W - 1;
  localparam int KEEP = 6;
  localparam int GATE = 5;
  localparam int LAMP = 4;
  localparam int POFF = 3;
  localparam int CPUB = 2;
  localparam int TICK = 1;
  localparam int DOGB = 0;

  logic [W-1:0] ctl_q;
  logic         stable;
  logic         auto_clr;
  logic         sel_next;

  assign auto_eff = auto_in | ctl_q[POFF];
  assign stable   = (auto_eff & lock_in) | (~auto_eff & track_in);
  assign auto_clr = stop_enter | selfclk_enter | (wait_enter & ctl_q[POFF]);

  always_comb begin
    sel_next = ctl_q[SEL];
    if (wr_en) sel_next = wr_data[SEL] ? (ctl_q[SEL] | stable) : 1'b0;
    if (auto_clr) sel_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q[SEL] <= sel_next;
      if (wr_en) ctl_q[SEL-1:0] <= wr_data[SEL-1:0];
    end
  end

  assign rd_data     = ctl_q;
  assign pll_sel     = ctl_q[SEL];
  assign pll_pwrdn   = in_wait & ctl_q[POFF];
  assign sys_clk_off = in_wait & ctl_q[GATE];
  assign osc_en      = ~in_stop | ctl_q[KEEP];
  assign osc_low_amp = (in_wait & ctl_q[LAMP]) | (in_stop & ctl_q[KEEP]);
  assign cpu_stop    = in_wait & ctl_q[CPUB];
  assign tick_stop   = in_wait & ctl_q[TICK];
  assign dog_stop    = in_wait & ctl_q[DOGB];
endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       lock_in,
  input logic       track_in,
  input logic       wait_enter,
  input logic       stop_enter,
  input logic       selfclk_enter,
  input logic       pll_sel,
  input logic       auto_eff
);
  // R3
  refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && !pll_sel && !((auto_eff && lock_in) || (!auto_eff && track_in)))
    |=> !pll_sel);

  // R2
  rise_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_sel) |-> $past(wr_en && wr_data[7]));

  // R5
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_enter || selfclk_enter) |=> !pll_sel);

  // R6
  wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_enter && rd_data[3]) |=> !pll_sel);

  // R4
  forced_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] |-> auto_eff);

  // R8
  hold_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[6:0]));
endmodule

bind clk_src_sel_reg clk_src_sel_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .lock_in(lock_in), .track_in(track_in), .wait_enter(wait_enter),
  .stop_enter(stop_enter), .selfclk_enter(selfclk_enter),
  .pll_sel(pll_sel), .auto_eff(auto_eff)
);

// File: tb/test_clk_src_sel_reg.sv
module test_clk_src_sel_reg;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic lock_in = 0, track_in = 0, auto_in = 0;
  logic wait_enter = 0, stop_enter = 0, selfclk_enter = 0;
  logic in_wait = 0, in_stop = 0;
  logic pll_sel, auto_eff, pll_pwrdn, sys_clk_off, osc_en, osc_low_amp;
  logic cpu_stop, tick_stop, dog_stop;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  clk_src_sel_reg i_clk_src_sel_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .lock_in(lock_in), .track_in(track_in), .auto_in(auto_in),
    .wait_enter(wait_enter), .stop_enter(stop_enter), .selfclk_enter(selfclk_enter),
    .in_wait(in_wait), .in_stop(in_stop), .pll_sel(pll_sel), .auto_eff(auto_eff),
    .pll_pwrdn(pll_pwrdn), .sys_clk_off(sys_clk_off), .osc_en(osc_en),
    .osc_low_amp(osc_low_amp), .cpu_stop(cpu_stop), .tick_stop(tick_stop),
    .dog_stop(dog_stop)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic status(logic a, logic l, logic t);
    @(negedge clk); auto_in = a; lock_in = l; track_in = t;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) stop_enter = 1;
    else if (which == 1) selfclk_enter = 1;
    else wait_enter = 1;
    @(negedge clk);
    stop_enter = 0; selfclk_enter = 0; wait_enter = 0;
  endtask

  task automatic t_reset;
    chk("R1 reg", rd_data, 8'h00);
    chk("R1 sel", pll_sel, 0);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 outs", {pll_pwrdn, sys_clk_off, osc_low_amp, cpu_stop, tick_stop, dog_stop}, 0);
  endtask

  task automatic t_accept;
    status(1, 1, 0); wr(8'h80);
    chk("R2 set via lock", pll_sel, 1);
    wr(8'h00);
    chk("R2 clear", pll_sel, 0);
    status(0, 0, 1); wr(8'h80);
    chk("R4 set via track", pll_sel, 1);
    wr(8'h00);
  endtask

  task automatic t_refuse;
    status(1, 0, 0); wr(8'h80); chk("R3 auto lock0 track0", pll_sel, 0);
    status(1, 0, 1); wr(8'h80); chk("R3 auto lock0 track1", pll_sel, 0);
    status(0, 0, 0); wr(8'h80); chk("R3 noauto track0 lock0", pll_sel, 0);
    status(0, 1, 0); wr(8'h80); chk("R3 noauto track0 lock1", pll_sel, 0);
    status(1, 1, 0); wr(8'h80);
    status(1, 0, 0); wr(8'hA0);
    chk("R3 keep set", rd_data, 8'hA0);
    wr(8'h00);
  endtask

  task automatic t_forced;
    status(0, 1, 0); wr(8'h08);
    chk("R4 auto_eff forced", auto_eff, 1);
    wr(8'h88);
    chk("R4 forced auto accept", rd_data, 8'h88);
    wr(8'h00);
    chk("R4 auto_eff released", auto_eff, 0);
  endtask

  task automatic t_clears;
    status(1, 1, 0); wr(8'hC5);
    pulse(0);
    chk("R5 stop clear", rd_data, 8'h45);
    wr(8'hC5);
    pulse(1);
    chk("R5 selfclk clear", rd_data, 8'h45);
    wr(8'h00);
  endtask

  task automatic t_wait;
    status(1, 1, 0); wr(8'h80);
    pulse(2);
    chk("R6 no clear bit3=0", rd_data, 8'h80);
    wr(8'h88);
    pulse(2);
    chk("R6 clear bit3=1", rd_data, 8'h08);
    @(negedge clk); in_wait = 1; #1;
    chk("R9 pll_pwrdn", pll_pwrdn, 1);
    repeat (3) @(negedge clk);
    in_wait = 0;
    repeat (4) @(negedge clk);
    chk("R6 stays clear", pll_sel, 0);
    wr(8'h00);
  endtask

  task automatic t_priority;
    status(1, 1, 0); wr(8'h80);
    @(negedge clk); wr_en = 1; wr_data = 8'h92; stop_enter = 1;
    @(negedge clk); wr_en = 0; stop_enter = 0;
    chk("R7 clear wins", rd_data, 8'h12);
    @(negedge clk); wr_en = 1; wr_data = 8'h84; selfclk_enter = 1;
    @(negedge clk); wr_en = 0; selfclk_enter = 0;
    chk("R7 clear wins from 0", rd_data, 8'h04);
    wr(8'h00);
  endtask

  task automatic t_modes;
    wr(8'h7F);
    chk("R8 readback", rd_data, 8'h7F);
    repeat (3) @(negedge clk);
    chk("R8 hold", rd_data, 8'h7F);
    @(negedge clk); in_wait = 1; #1;
    chk("R9 wait outs", {pll_pwrdn, sys_clk_off}, 2'b11);
    chk("R10 wait low amp", {osc_en, osc_low_amp}, 2'b11);
    chk("R11 wait stops", {cpu_stop, tick_stop, dog_stop}, 3'b111);
    wr(8'h05);
    chk("R11 partial", {cpu_stop, tick_stop, dog_stop}, 3'b101);
    chk("R9 off", {pll_pwrdn, sys_clk_off}, 2'b00);
    @(negedge clk); in_wait = 0; in_stop = 1; #1;
    chk("R10 stop no keep", {osc_en, osc_low_amp}, 2'b00);
    wr(8'h40);
    chk("R10 stop keep", {osc_en, osc_low_amp}, 2'b11);
    @(negedge clk); in_stop = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_accept();
    t_refuse();
    t_forced();
    t_clears();
    t_wait();
    t_priority();
    t_modes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule